// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block chooses which of five interrupt sources a CPU services next and gives it the matching vector. The sources are external pin 0, timer 0 overflow, external pin 1, timer 1 overflow and the combined serial flag. Two registers set its behaviour. The enable register holds one global enable and one enable per source. The priority register holds one bit per source. Each external pin can be set to request on a low level or to latch a falling edge.

The arbiter asserts a request together with a 16-bit vector address. When the CPU accepts the request, it pulses an acknowledge. The arbiter keeps one in-service bit for each of the two priority levels, so nested handlers follow the two-level rules. A return strobe from the CPU ends the highest active level. On acknowledge, the arbiter clears the latched edge flag of a granted external source itself. For a granted timer it emits a one-cycle clear pulse to the timer, and the serial flag is left for software to clear. Pushing the return address on the stack belongs to the CPU and is not part of this block.

Top module: `irq_arbiter2`

## Requirements
- R1: After reset, the enable register, the priority register, both in-service bits and both latched edge flags are zero, and no request is raised.
- R2: While the global enable (write-data bit 7 of the enable register) is 0, no request is raised, whatever the source enables are. Enable bits 6 and 5 have no effect.
- R3: The source enables are enable-register bits 0 (pin 0), 1 (timer 0), 2 (pin 1), 3 (timer 1) and 4 (serial). A disabled source is never granted.
- R4: The priority register uses the same bit positions, and 1 means high. A pending high-priority source wins over any low-priority source.
- R5: Within one level, the lowest bit position wins: pin 0, then timer 0, pin 1, timer 1, serial. The vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. The vector output is 0 while no request is raised.
- R6: While only the low in-service bit is set, low-priority sources are not granted, and a high-priority source is granted.
- R7: While the high in-service bit is set, no request is raised.
- R8: An acknowledge taken while a request is raised sets the in-service bit of the granted source's level in the next cycle. An acknowledge taken with no request does nothing. A return strobe clears the high bit if it is set, otherwise the low bit. With neither bit set, the return strobe has no effect.
- R9: With edge mode selected for a pin, a high-to-low transition latches that pin's flag one cycle later. The flag requests service until that source is acknowledged, which clears it. A pin held low after the clear raises no new request.
- R10: With level mode selected for a pin, the pin requests service exactly while it is low, and nothing is latched.
- R11: Acknowledging timer 0 or timer 1 pulses the matching bit of the timer-clear output (bit 0 or bit 1) in the acknowledge cycle. No other acknowledge pulses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| pri_wr | input | 1 | Write strobe for the priority register |
| wr_data | input | 8 | Write data for both registers |
| edge_mode | input | 2 | Per-pin trigger select, 1 = falling edge, 0 = low level |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 timer 0, bit 1 timer 1) |
| ser_flag | input | 1 | Combined serial receive/transmit flag |
| ack | input | 1 | CPU accepts the current request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Service request to the CPU |
| irq_vector | output | 16 | Vector address of the granted source |
| tmr_clr | output | 2 | One-cycle clear pulse to the timer flags |
| ext_flag | output | 2 | Latched falling-edge flags |
| lvl_active | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The hardest state to reach from the ports is a nested one: both in-service bits set while requests of both levels stay pending. The stimulus gets there by first granting a low-priority timer and holding its flag up. A high-priority source is then raised and granted as well, so that the blocking rules for each level and the order in which the return strobe unwinds are all observed. A second hard case is an edge flag that is latched while its pin is still low and then cleared by the acknowledge. The bench shows that the steady low level produces no new request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned SRC_N   = 5;
  localparam int unsigned EXT_N   = 2;
  localparam int unsigned LVL_N   = 2;
  localparam int unsigned IDX_W   = $clog2(SRC_N);
  localparam int unsigned VEC_W   = 16;

  // source bit positions; the polling order follows these
  localparam int unsigned SRC_PIN0 = 0;
  localparam int unsigned SRC_TMR0 = 1;
  localparam int unsigned SRC_PIN1 = 2;
  localparam int unsigned SRC_TMR1 = 3;
  localparam int unsigned SRC_SER  = 4;
  localparam int unsigned EN_GLOBAL = 7;

  typedef logic [SRC_N-1:0] src_vec_t;
  typedef logic [LVL_N-1:0] lvl_vec_t;
endpackage

// File: rtl/irq_ext_trig.sv
module irq_ext_trig
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_PINS = EXT_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic [NUM_PINS-1:0] edge_sel,
  input  logic [NUM_PINS-1:0] flag_clr,
  output logic [NUM_PINS-1:0] pin_req,
  output logic [NUM_PINS-1:0] flag
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic pin_q;
    logic flag_q;
    logic flag_d;
    logic fall;

    assign fall = pin_q & ~pin_n[g];

    always_comb begin
      if (edge_sel[g]) flag_d = (flag_q & ~flag_clr[g]) | fall;
      else             flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_q  <= 1'b1;
        flag_q <= 1'b0;
      end else begin
        pin_q  <= pin_n[g];
        flag_q <= flag_d;
      end
    end

    assign pin_req[g] = edge_sel[g] ? flag_q : ~pin_n[g];
    assign flag[g]    = flag_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_N,
  localparam int unsigned IW     = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] pri,
  input  logic               allow_hi,
  input  logic               allow_lo,
  output logic               grant_vld,
  output logic               grant_hi,
  output logic [IW-1:0]      grant_idx,
  output logic [NUM_SRC-1:0] grant_oh
);
  logic [NUM_SRC-1:0] cand_hi;
  logic [NUM_SRC-1:0] cand_lo;
  logic [NUM_SRC-1:0] cand;

  assign cand_hi  = pend & pri & {NUM_SRC{allow_hi}};
  assign cand_lo  = pend & ~pri & {NUM_SRC{allow_lo}};
  assign grant_hi = |cand_hi;
  assign cand     = grant_hi ? cand_hi : cand_lo;

  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    grant_oh  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant_vld = 1'b1;
        grant_idx = IW'(i);
        grant_oh  = '0;
        grant_oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  logic     take_hi,
  input  logic     reti,
  output lvl_vec_t active
);
  lvl_vec_t act_q;
  lvl_vec_t act_d;
  lvl_vec_t clr_mask;
  lvl_vec_t set_mask;

  always_comb begin
    clr_mask = '0;
    if (reti) begin
      if (act_q[1])      clr_mask = 2'b10;
      else if (act_q[0]) clr_mask = 2'b01;
    end
    set_mask = '0;
    if (take) set_mask = take_hi ? 2'b10 : 2'b01;
    act_d = (act_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign active = act_q;
endmodule

// File: rtl/irq_arbiter2.sv
module irq_arbiter2
  import irq_arb_pkg::*;
#(
  parameter logic [15:0] VEC_BASE   = 16'h0003,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        pri_wr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  edge_mode,
  input  logic [1:0]  ext_n,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_flag,
  input  logic        ack,
  input  logic        reti,
  output logic        irq_req,
  output logic [15:0] irq_vector,
  output logic [1:0]  tmr_clr,
  output logic [1:0]  ext_flag,
  output logic [1:0]  lvl_active
);
  localparam logic [15:0] STRIDE = 16'(VEC_STRIDE);

  logic     en_glb_q;
  src_vec_t en_src_q;
  src_vec_t pri_q;
  logic     unused_wr;

  assign unused_wr = ^wr_data[6:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_glb_q <= 1'b0;
      en_src_q <= '0;
    end else if (en_wr) begin
      en_glb_q <= wr_data[EN_GLOBAL];
      en_src_q <= wr_data[SRC_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pri_q <= '0;
    else if (pri_wr) pri_q <= wr_data[SRC_N-1:0];
  end

  logic [EXT_N-1:0] pin_req;
  logic [EXT_N-1:0] pin_clr;

  irq_ext_trig #(.NUM_PINS(EXT_N)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (ext_n),
    .edge_sel (edge_mode),
    .flag_clr (pin_clr),
    .pin_req  (pin_req),
    .flag     (ext_flag)
  );

  src_vec_t src_raw;
  src_vec_t pend;
  lvl_vec_t act;

  always_comb begin
    src_raw           = '0;
    src_raw[SRC_PIN0] = pin_req[0];
    src_raw[SRC_TMR0] = tmr_ovf[0];
    src_raw[SRC_PIN1] = pin_req[1];
    src_raw[SRC_TMR1] = tmr_ovf[1];
    src_raw[SRC_SER]  = ser_flag;
  end

  assign pend = src_raw & en_src_q & {SRC_N{en_glb_q}};

  logic             grant_vld;
  logic             grant_hi;
  logic [IDX_W-1:0] grant_idx;
  src_vec_t         grant_oh;

  irq_prio_pick #(.NUM_SRC(SRC_N)) u_pick (
    .pend      (pend),
    .pri       (pri_q),
    .allow_hi  (~act[1]),
    .allow_lo  (~|act),
    .grant_vld (grant_vld),
    .grant_hi  (grant_hi),
    .grant_idx (grant_idx),
    .grant_oh  (grant_oh)
  );

  logic take;
  assign take = ack & grant_vld;

  irq_level_track u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_hi (grant_hi),
    .reti    (reti),
    .active  (act)
  );

  assign pin_clr[0] = take & grant_oh[SRC_PIN0];
  assign pin_clr[1] = take & grant_oh[SRC_PIN1];
  assign tmr_clr[0] = take & grant_oh[SRC_TMR0];
  assign tmr_clr[1] = take & grant_oh[SRC_TMR1];

  assign irq_req    = grant_vld;
  assign irq_vector = grant_vld ? VEC_BASE + 16'(grant_idx) * STRIDE : 16'h0000;
  assign lvl_active = act;
endmodule

// File: rtl/irq_arbiter2_chk.sv
module irq_arbiter2_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ea,
  input logic        irq_req,
  input logic [15:0] irq_vector,
  input logic        ack,
  input logic        reti,
  input logic [1:0]  tmr_clr,
  input logic [1:0]  lvl_active
);
  AST_GLOBAL_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |-> !irq_req); // R2

  AST_HIGH_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_active[1] |-> !irq_req); // R7

  AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !reti) |=> (lvl_active != 2'b00)); // R8

  AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req && !reti) |=> $stable(lvl_active)); // R8

  AST_RETI_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && lvl_active == 2'b00) |=> (lvl_active == 2'b00)); // R8

  AST_TMR_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_clr)); // R11

  AST_TMR_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr != 2'b00) |-> (ack && irq_req)); // R11

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector[2:0] == 3'b011 && irq_vector <= 16'h0023)); // R5
endmodule

bind irq_arbiter2 irq_arbiter2_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ea         (en_glb_q),
  .irq_req    (irq_req),
  .irq_vector (irq_vector),
  .ack        (ack),
  .reti       (reti),
  .tmr_clr    (tmr_clr),
  .lvl_active (lvl_active)
);

// File: tb/irq_arbiter2_tb.sv
module irq_arbiter2_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_wr, pri_wr;
  logic [7:0]  wr_data;
  logic [1:0]  edge_mode, ext_n, tmr_ovf;
  logic        ser_flag, ack, reti;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic [1:0]  tmr_clr, ext_flag, lvl_active;

  always #5 clk = ~clk;

  irq_arbiter2 u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .pri_wr(pri_wr), .wr_data(wr_data),
    .edge_mode(edge_mode), .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_flag(ser_flag),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vector(irq_vector),
    .tmr_clr(tmr_clr), .ext_flag(ext_flag), .lvl_active(lvl_active)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // source bits: 0 pin0, 1 timer0, 2 pin1, 3 timer1, 4 serial
  task automatic set_src(input logic [4:0] s);
    ext_n[0]   = ~s[0];
    tmr_ovf[0] = s[1];
    ext_n[1]   = ~s[2];
    tmr_ovf[1] = s[3];
    ser_flag   = s[4];
  endtask

  task automatic wr_en(input logic [7:0] d);
    en_wr = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic wr_pri(input logic [7:0] d);
    pri_wr = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    pri_wr = 1'b0;
  endtask

  task automatic pulse_ack;
    ack = 1'b1; @(posedge clk); @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_reti;
    reti = 1'b1; @(posedge clk); @(negedge clk); reti = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0]  en;
    logic [4:0]  pri;
    logic [4:0]  src;
    logic        req;
    logic [15:0] vec;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{8'h9F, 5'b00000, 5'b11111, 1'b1, 16'h0003},  // R5 pin0 first
    '{8'h9F, 5'b00000, 5'b11110, 1'b1, 16'h000B},  // R5 timer0 next
    '{8'h9F, 5'b10000, 5'b11111, 1'b1, 16'h0023},  // R4 serial high
    '{8'h9F, 5'b01000, 5'b11111, 1'b1, 16'h001B},  // R4 timer1 high
    '{8'h1F, 5'b00000, 5'b11111, 1'b0, 16'h0000},  // R2 global off
    '{8'h9E, 5'b00000, 5'b00001, 1'b0, 16'h0000},  // R3 pin0 disabled
    '{8'h9E, 5'b00000, 5'b00101, 1'b1, 16'h0013},  // R3 pin1 taken
    '{8'h88, 5'b00000, 5'b11111, 1'b1, 16'h001B},  // R3 only timer1
    '{8'h9F, 5'b00110, 5'b00111, 1'b1, 16'h000B},  // R4/R5 order in high
    '{8'hF0, 5'b00000, 5'b10000, 1'b1, 16'h0023},  // R2 reserved bits
    '{8'h9F, 5'b00000, 5'b00000, 1'b0, 16'h0000},  // R5 nothing pending
    '{8'h9F, 5'b11111, 5'b10100, 1'b1, 16'h0013}   // R5 all high
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_wr = 0; pri_wr = 0; wr_data = 0; edge_mode = 0;
    ack = 0; reti = 0;
    set_src(5'b11111);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 req", irq_req, 0);
    chk("R1 lvl", lvl_active, 0);
    chk("R1 flag", ext_flag, 0);

    for (int i = 0; i < NV; i++) begin
      wr_en(TBL[i].en);
      wr_pri({3'b000, TBL[i].pri});
      set_src(TBL[i].src);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R2-5 vec%0d req", i), irq_req, TBL[i].req);
      chk($sformatf("R5 vec%0d vector", i), irq_vector, TBL[i].vec);
    end

    // nesting: timer0 high, others low
    wr_en(8'h9F); wr_pri(8'h02); set_src(5'b01000);
    @(posedge clk); @(negedge clk);
    chk("R5 tmr1 low vec", irq_vector, 16'h001B);
    ack = 1'b1; #1;
    chk("R11 clr tmr1", tmr_clr, 2'b10);
    @(posedge clk); @(negedge clk); ack = 1'b0;
    chk("R8 low set", lvl_active, 2'b01);
    set_src(5'b11101);
    #1;
    chk("R6 low blocks low", irq_req, 0);
    set_src(5'b11111);
    #1;
    chk("R6 high preempts", irq_vector, 16'h000B);
    ack = 1'b1; #1;
    chk("R11 clr tmr0", tmr_clr, 2'b01);
    @(posedge clk); @(negedge clk); ack = 1'b0;
    chk("R8 both set", lvl_active, 2'b11);
    chk("R7 high blocks", irq_req, 0);
    pulse_ack;
    chk("R8 idle ack", lvl_active, 2'b11);
    pulse_reti;
    chk("R8 reti high first", lvl_active, 2'b01);
    pulse_reti;
    chk("R8 reti low", lvl_active, 2'b00);
    pulse_reti;
    chk("R8 reti empty", lvl_active, 2'b00);

    // serial ack: no timer clear
    set_src(5'b10000);
    @(posedge clk); @(negedge clk);
    ack = 1'b1; #1;
    chk("R11 serial no clr", tmr_clr, 2'b00);
    @(posedge clk); @(negedge clk); ack = 1'b0;
    pulse_reti;

    // level mode pin1
    wr_en(8'h84); wr_pri(8'h00); set_src(5'b00100);
    #1;
    chk("R10 level low req", irq_vector, 16'h0013);
    chk("R10 no latch", ext_flag, 2'b00);
    set_src(5'b00000);
    #1;
    chk("R10 level released", irq_req, 0);

    // edge mode pin0
    wr_en(8'h81); edge_mode = 2'b01;
    set_src(5'b00001);
    #1;
    chk("R9 no req before edge", irq_req, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 flag latched", ext_flag, 2'b01);
    chk("R9 req vec", irq_vector, 16'h0003);
    pulse_ack;
    chk("R9 flag cleared", ext_flag, 2'b00);
    pulse_reti;
    chk("R9 steady low ignored", irq_req, 0);
    set_src(5'b00000);
    @(posedge clk); @(negedge clk);
    set_src(5'b00001);
    @(posedge clk); @(negedge clk);
    set_src(5'b00000);
    @(posedge clk); @(negedge clk);
    chk("R9 second edge held", irq_vector, 16'h0003);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule